// File: doc/BRIEF.md
# I2C Serial Clock Timing Generator

This block produces the serial clock waveform for an I2C controller from a fast system clock. Each clock phase is measured in prescaled ticks. A tick is 2^base system cycles, and the high and low phases each last a programmed number of ticks. Both phase counts are stored as the length minus one, so every phase is at least one tick long. The SCL output is an open-drain pull-low request. The block also gives the byte engine single-cycle strobes at the falling edge, the rising edge and the middle of each phase. The byte engine uses these to change and sample SDA.

The byte engine turns the generator on with an enable input and supplies a 20-bit timing word. The word is captured only when a low phase begins, so a new setting never distorts the period in progress. After the line is released, the high phase is not counted until the sensed SCL line is actually high. A target that holds SCL low therefore stretches the clock, and the full programmed high time still follows. A system clock divisor d is usually set with a high count of at least 8 ticks and a low count of at least 7 ticks. When the total is odd, the extra tick goes to the high phase.

Top module: `scl_timing_gen`

## Requirements
- R1: While reset is asserted, and in every cycle after the block samples enable low at a clock edge, SCL is released (sclPullLow = 0) and no strobe is asserted.
- R2: When enable is sampled high while the block is idle, sclPullLow goes to 1 in the next cycle, and fallStb is asserted in that same first low cycle.
- R3: A low phase lasts (L+1)·2^B system cycles, where B = timingWord[3:0] and L = timingWord[15:12]. During all of these cycles sclPullLow is 1, and riseStb can first appear in the cycle after the last low cycle.
- R4: A high phase lasts (H+1)·2^B system cycles, where H = timingWord[19:16]. It is counted from the first cycle in which sclIn is 1 after release, and that cycle carries riseStb. The next fallStb comes directly after the last high cycle.
- R5: After release, while sclIn stays 0, the high phase does not advance. riseStb is asserted in the first cycle in which sclIn is 1, and the full high time follows from that cycle.
- R6: midLowStb is asserted ((L+1)>>1)·2^B cycles after the fallStb cycle. midHighStb is asserted ((H+1)>>1)·2^B cycles after the riseStb cycle. An offset of 0 means the same cycle.
- R7: The timing word is captured only when a low phase begins, either from idle or at the end of a high phase. A change during a period has no effect until the next low phase. Bits [11:4] are reserved and must be zero.
- R8: Each strobe is asserted for one system cycle at a time. riseStb and fallStb are never asserted together.
- R9: Dropping enable in the middle of a phase releases SCL in the next cycle. Raising enable again starts a fresh low phase of full length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run request from the byte engine |
| timingWord | input | 20 | Base exponent [3:0], low count [15:12], high count [19:16] |
| sclIn | input | 1 | Sensed SCL line level |
| sclPullLow | output | 1 | Open-drain drive: 1 pulls SCL low |
| riseStb | output | 1 | First cycle of the high phase |
| fallStb | output | 1 | First cycle of the low phase |
| midHighStb | output | 1 | Middle of the high phase |
| midLowStb | output | 1 | Middle of the low phase |

## Verification
A wrong prescaler or phase count shows up within a single SCL period. In that case the gap between fallStb and riseStb, or between riseStb and the next fallStb, differs from (n+1)·2^B. The bench sweeps every combination of a small range of base, high and low values and measures both gaps and both midpoints.

A phase-state or capture error shows up at the next phase boundary. Examples are counting during a stretch, a rise strobe before the line is high, or a timing word taken mid-period. The bench checks these with held-low stretches, word changes at mid-low, and disables in the middle of a phase.

// File: rtl/sclgen_pkg.sv
package sclgen_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOW  = 2'd1,
    ST_HIGH = 2'd2
  } sclState_t;

  // control -> datapath
  typedef struct packed {
    logic loadCfg;
    logic clrCnt;
    logic countEn;
    logic inHigh;
  } dpCtrl_t;

  // datapath -> control (raw, not gated by countEn)
  typedef struct packed {
    logic phaseEnd;
    logic midPoint;
  } dpStat_t;

endpackage

// File: rtl/sclgen_dpath.sv
module sclgen_dpath
  import sclgen_pkg::*;
#(
  parameter int EXP_W    = 4,
  parameter int CNT_W    = 4,
  parameter int WORD_W   = 20,
  parameter int BASE_LSB = 0,
  parameter int LOW_LSB  = 12,
  parameter int HIGH_LSB = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [WORD_W-1:0] timingWord,
  input  dpCtrl_t           ctl,
  output dpStat_t           stat
);

  localparam int PRE_W  = (2 ** EXP_W) - 1;
  localparam int RSV_LO = BASE_LSB + EXP_W;
  localparam int RSV_HI = LOW_LSB - 1;

  logic [EXP_W-1:0] baseQ;
  logic [CNT_W-1:0] lowQ;
  logic [CNT_W-1:0] highQ;
  logic [PRE_W-1:0] preCnt;
  logic [CNT_W-1:0] phCnt;
  logic [PRE_W:0]   preLim;
  logic [PRE_W-1:0] preMax;
  logic [CNT_W-1:0] phLen;
  logic [CNT_W:0]   midIdx;
  logic             tickEnd;

  // captured configuration
  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseQ <= '0;
      lowQ  <= '0;
      highQ <= '0;
    end else if (ctl.loadCfg) begin
      baseQ <= timingWord[BASE_LSB +: EXP_W];
      lowQ  <= timingWord[LOW_LSB +: CNT_W];
      highQ <= timingWord[HIGH_LSB +: CNT_W];
    end
  end

  always_comb begin
    preLim  = ({{PRE_W{1'b0}}, 1'b1} << baseQ) - {{PRE_W{1'b0}}, 1'b1};
    preMax  = preLim[PRE_W-1:0];
    phLen   = ctl.inHigh ? highQ : lowQ;
    midIdx  = ({1'b0, phLen} + {{CNT_W{1'b0}}, 1'b1}) >> 1;
    tickEnd = (preCnt == preMax);
    stat.phaseEnd = tickEnd && (phCnt == phLen);
    stat.midPoint = (preCnt == '0) && ({1'b0, phCnt} == midIdx);
  end

  // prescaler and phase tick counter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCnt <= '0;
      phCnt  <= '0;
    end else if (ctl.clrCnt) begin
      preCnt <= '0;
      phCnt  <= '0;
    end else if (ctl.countEn) begin
      if (tickEnd) begin
        preCnt <= '0;
        phCnt  <= phCnt + {{(CNT_W-1){1'b0}}, 1'b1};
      end else begin
        preCnt <= preCnt + {{(PRE_W-1){1'b0}}, 1'b1};
      end
    end
  end

  // R3: prescaler never passes its limit
  a_r3_pre_in_range: assert property (@(posedge clk) disable iff (!rstN)
    preCnt <= preMax);

  // R4: phase counter never passes the phase length
  a_r4_ph_in_range: assert property (@(posedge clk) disable iff (!rstN)
    phCnt <= phLen);

  // R5: no counting while the line is held low in the high phase
  a_r5_hold_while_stretched: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.countEn && !ctl.clrCnt) |=> ($stable(preCnt) && $stable(phCnt)));

  // R7: reserved bits are zero whenever a word is captured
  a_r7_reserved_zero: assert property (@(posedge clk) disable iff (!rstN)
    ctl.loadCfg |-> (timingWord[RSV_HI:RSV_LO] == '0));

endmodule

// File: rtl/sclgen_ctrl.sv
module sclgen_ctrl
  import sclgen_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    enable,
  input  logic    sclIn,
  input  dpStat_t stat,
  output dpCtrl_t ctl,
  output logic    sclPullLow,
  output logic    riseStb,
  output logic    fallStb,
  output logic    midHighStb,
  output logic    midLowStb
);

  sclState_t state, stateNx;
  logic started, startedNx;
  logic firstLow, firstLowNx;
  logic cntEn;
  logic phDone;

  always_comb begin
    cntEn  = (state == ST_LOW) || ((state == ST_HIGH) && (started || sclIn));
    phDone = cntEn && stat.phaseEnd;
  end

  always_comb begin
    ctl         = '0;
    ctl.countEn = cntEn;
    ctl.inHigh  = (state == ST_HIGH);
    stateNx     = state;
    startedNx   = started;
    firstLowNx  = 1'b0;
    case (state)
      ST_IDLE: begin
        ctl.clrCnt = 1'b1;
        if (enable) begin
          stateNx     = ST_LOW;
          ctl.loadCfg = 1'b1;
          firstLowNx  = 1'b1;
        end
      end
      ST_LOW: begin
        if (phDone) begin
          ctl.clrCnt = 1'b1;
          stateNx    = ST_HIGH;
          startedNx  = 1'b0;
        end
      end
      ST_HIGH: begin
        startedNx = started || sclIn;
        if (phDone) begin
          ctl.clrCnt  = 1'b1;
          ctl.loadCfg = 1'b1;
          stateNx     = ST_LOW;
          firstLowNx  = 1'b1;
          startedNx   = 1'b0;
        end
      end
      default: begin
        ctl.clrCnt = 1'b1;
        stateNx    = ST_IDLE;
      end
    endcase
    if (!enable) begin
      stateNx     = ST_IDLE;
      ctl.clrCnt  = 1'b1;
      ctl.loadCfg = 1'b0;
      firstLowNx  = 1'b0;
      startedNx   = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      started  <= 1'b0;
      firstLow <= 1'b0;
    end else begin
      state    <= stateNx;
      started  <= startedNx;
      firstLow <= firstLowNx;
    end
  end

  always_comb begin
    sclPullLow = (state == ST_LOW);
    fallStb    = (state == ST_LOW) && firstLow;
    riseStb    = (state == ST_HIGH) && !started && sclIn;
    midLowStb  = (state == ST_LOW) && stat.midPoint;
    midHighStb = (state == ST_HIGH) && cntEn && stat.midPoint;
  end

  // R1: a low enable releases the line on the next cycle
  a_r1_release_when_off: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (!sclPullLow && !fallStb && !riseStb));

  // R2: every start of pull-low carries the fall strobe
  a_r2_fall_with_drive: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sclPullLow) |-> fallStb);

  // R8: strobes are one cycle wide and rise/fall are exclusive
  a_r8_fall_single: assert property (@(posedge clk) disable iff (!rstN)
    fallStb |=> !fallStb);
  a_r8_rise_single: assert property (@(posedge clk) disable iff (!rstN)
    riseStb |=> !riseStb);
  a_r8_rise_fall_excl: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({riseStb, fallStb}));

endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
  import sclgen_pkg::*;
#(
  parameter int EXP_W    = 4,
  parameter int CNT_W    = 4,
  parameter int BASE_LSB = 0,
  parameter int LOW_LSB  = 12,
  parameter int HIGH_LSB = 16,
  parameter int WORD_W   = HIGH_LSB + CNT_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic [WORD_W-1:0] timingWord,
  input  logic              sclIn,
  output logic              sclPullLow,
  output logic              riseStb,
  output logic              fallStb,
  output logic              midHighStb,
  output logic              midLowStb
);

  dpCtrl_t ctl;
  dpStat_t stat;

  sclgen_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .enable     (enable),
    .sclIn      (sclIn),
    .stat       (stat),
    .ctl        (ctl),
    .sclPullLow (sclPullLow),
    .riseStb    (riseStb),
    .fallStb    (fallStb),
    .midHighStb (midHighStb),
    .midLowStb  (midLowStb)
  );

  sclgen_dpath #(
    .EXP_W    (EXP_W),
    .CNT_W    (CNT_W),
    .WORD_W   (WORD_W),
    .BASE_LSB (BASE_LSB),
    .LOW_LSB  (LOW_LSB),
    .HIGH_LSB (HIGH_LSB)
  ) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .timingWord (timingWord),
    .ctl        (ctl),
    .stat       (stat)
  );

endmodule

// File: tb/scl_timing_gen_bench.sv
`timescale 1ns/1ps
module scl_timing_gen_bench;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0;
  logic [19:0] timingWord = '0;
  logic holdLow = 1'b0;
  logic sclIn;
  logic sclPullLow, riseStb, fallStb, midHighStb, midLowStb;

  always #2.5 clk = ~clk;

  assign sclIn = !sclPullLow && !holdLow;

  scl_timing_gen u_scl_timing_gen (
    .clk        (clk),
    .rstN       (rstN),
    .enable     (enable),
    .timingWord (timingWord),
    .sclIn      (sclIn),
    .sclPullLow (sclPullLow),
    .riseStb    (riseStb),
    .fallStb    (fallStb),
    .midHighStb (midHighStb),
    .midLowStb  (midLowStb)
  );

  int nChecks = 0;
  int nFails  = 0;
  int cyc = 0;
  int nFall = 0, nRise = 0, nMidL = 0;
  int fallT = 0, riseT = 0, midLT = 0, midHT = 0;
  int lowRun = 0, lowAtRise = 0;
  int widthErr = 0, exclErr = 0;
  logic pF = 0, pR = 0, pML = 0, pMH = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    cyc++;
    if (fallStb) begin nFall++; fallT = cyc; lowRun = 0; end
    if (sclPullLow) lowRun++;
    if (riseStb) begin nRise++; riseT = cyc; lowAtRise = lowRun; end
    if (midLowStb) begin nMidL++; midLT = cyc; end
    if (midHighStb) midHT = cyc;
    if ((fallStb && pF) || (riseStb && pR) || (midLowStb && pML) || (midHighStb && pMH))
      widthErr++;
    if (fallStb && riseStb) exclErr++;
    pF = fallStb; pR = riseStb; pML = midLowStb; pMH = midHighStb;
  endtask

  task automatic waitFall();
    int n0 = nFall;
    for (int g = 0; g < 20000 && nFall == n0; g++) tick();
  endtask

  task automatic waitRise();
    int n0 = nRise;
    for (int g = 0; g < 20000 && nRise == n0; g++) tick();
  endtask

  task automatic waitMidL();
    int n0 = nMidL;
    for (int g = 0; g < 20000 && nMidL == n0; g++) tick();
  endtask

  function automatic logic [19:0] mkWord(input int b, input int h, input int l);
    return {h[3:0], l[3:0], 8'h00, b[3:0]};
  endfunction

  task automatic printSummary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
  endtask

  initial begin
    #1000000;
    nFails++;
    $display("FAIL watchdog: actual 1 expected 0 (hung run)");
    printSummary();
    $finish;
  end

  initial begin
    int enCyc, relCyc, anyAct;
    // R1: reset state
    for (int i = 0; i < 4; i++) tick();
    check(!sclPullLow && !fallStb && !riseStb && !midLowStb && !midHighStb,
          "R1 reset outputs", int'(sclPullLow), 0);
    rstN = 1'b1;
    anyAct = 0;
    for (int i = 0; i < 6; i++) begin
      tick();
      if (sclPullLow || fallStb || riseStb || midLowStb || midHighStb) anyAct++;
    end
    check(anyAct == 0, "R1 disabled idle", anyAct, 0);

    // sweep base 0..2, high 0..3, low 0..3
    for (int b = 0; b < 3; b++)
      for (int h = 0; h < 4; h++)
        for (int l = 0; l < 4; l++) begin
          enable = 1'b0;
          tick(); tick();
          timingWord = mkWord(b, h, l);
          enable = 1'b1;
          enCyc = cyc;
          waitFall();
          check(fallT == enCyc + 1, "R2 first fall", fallT - enCyc, 1);
          waitRise();
          check(riseT - fallT == ((l + 1) << b), "R3 low length", riseT - fallT, (l + 1) << b);
          check(lowAtRise == ((l + 1) << b), "R3 pull-low cycles", lowAtRise, (l + 1) << b);
          check(midLT - fallT == (((l + 1) >> 1) << b), "R6 mid-low offset",
                midLT - fallT, ((l + 1) >> 1) << b);
          waitFall();
          check(fallT - riseT == ((h + 1) << b), "R4 high length", fallT - riseT, (h + 1) << b);
          check(midHT - riseT == (((h + 1) >> 1) << b), "R6 mid-high offset",
                midHT - riseT, ((h + 1) >> 1) << b);
        end

    // R5: stretching by holding the line low 5 cycles after release
    enable = 1'b0;
    tick(); tick();
    timingWord = mkWord(1, 2, 1);
    holdLow = 1'b1;
    enable = 1'b1;
    waitFall();
    relCyc = 0;
    for (int g = 0; g < 1000 && relCyc == 0; g++) begin
      tick();
      if (!sclPullLow) relCyc = cyc;
    end
    check(lowRun == 4, "R5 low before stretch", lowRun, 4);
    while (cyc < relCyc + 4) tick();
    @(posedge clk);
    #1 holdLow = 1'b0;
    tick();
    check(riseStb && riseT == relCyc + 5, "R5 rise after stretch", riseT - relCyc, 5);
    waitFall();
    check(fallT - riseT == 6, "R5 full high after stretch", fallT - riseT, 6);

    // R7: word change mid-period takes effect at the next low phase
    enable = 1'b0;
    tick(); tick();
    timingWord = mkWord(0, 2, 3);
    enable = 1'b1;
    waitFall();
    waitMidL();
    timingWord = mkWord(1, 0, 2);
    waitRise();
    check(riseT - fallT == 4, "R7 old low kept", riseT - fallT, 4);
    waitFall();
    check(fallT - riseT == 3, "R7 old high kept", fallT - riseT, 3);
    waitRise();
    check(riseT - fallT == 6, "R7 new low applied", riseT - fallT, 6);
    waitFall();
    check(fallT - riseT == 2, "R7 new high applied", fallT - riseT, 2);

    // R9: disable mid-low, then restart
    enable = 1'b0;
    tick(); tick();
    timingWord = mkWord(1, 3, 3);
    enable = 1'b1;
    waitFall();
    tick(); tick(); tick();
    enable = 1'b0;
    tick();
    check(!sclPullLow, "R9 release after disable", int'(sclPullLow), 0);
    anyAct = 0;
    for (int i = 0; i < 4; i++) begin
      tick();
      if (sclPullLow || fallStb || riseStb || midLowStb || midHighStb) anyAct++;
    end
    check(anyAct == 0, "R1 quiet while disabled", anyAct, 0);
    enable = 1'b1;
    enCyc = cyc;
    waitFall();
    check(fallT == enCyc + 1, "R9 restart fall", fallT - enCyc, 1);
    waitRise();
    check(riseT - fallT == 8, "R9 full low after restart", riseT - fallT, 8);
    // disable during high phase
    tick();
    enable = 1'b0;
    tick();
    check(!sclPullLow && !fallStb, "R9 disable in high", int'(sclPullLow), 0);

    check(widthErr == 0, "R8 strobe width", widthErr, 0);
    check(exclErr == 0, "R8 rise/fall exclusive", exclErr, 0);

    printSummary();
    $finish;
  end

endmodule